// File: doc/BRIEF.md
# Two-Button Hold Reboot Controller

This block watches two active-low push buttons and a supply-good flag, and produces one active-low reset pulse of fixed length when both buttons are held down together for long enough. Time is measured in ticks: a one-cycle `tick_i` strobe stands in for a slow oscillator. One counter measures how long the buttons are held (`DELAY_TICKS`) and a second one sets how long the reset stays asserted (`PULSE_TICKS`).

Once the hold delay completes, the pulse always runs to its end, even if the buttons are let go. Afterwards the block waits for at least one button to be seen released before it can arm again, so a pulse cannot repeat while the buttons stay held. A supply-good drop overrides everything and sends the block back to standby with both counters cleared. The reset output is built in one of two styles, chosen by the `OPEN_DRAIN` parameter. In open-drain style it is an output enable plus a constant low level. In push-pull style it is a driven level. All inputs are assumed to be synchronous to `clk`.

Top module: `hold_reboot_ctrl`

## Requirements
- R1: `state_o` encodes the state as 0 = standby, 1 = measuring hold delay, 2 = pulsing, 3 = waiting for release. A low `rst_n` at a clock edge puts the block in standby with both counters cleared and the reset output released.
- R2: From standby the block moves to state 1 on the edge after a cycle in which both buttons are low and `supply_ok_i` is high. Otherwise it stays in standby.
- R3: A button input seen high during state 1 returns the block to standby on the next edge. A later attempt needs the full hold delay again.
- R4: `supply_ok_i` low in any state sends the block to standby on the next edge and clears both counters. This takes priority over the buttons.
- R5: With both buttons held and supply good, the block enters state 2 on the edge after the `DELAY_TICKS`-th tick counted in state 1.
- R6: State 2 ends on the edge after the `PULSE_TICKS`-th tick counted in it, whatever the buttons do meanwhile.
- R7: Open-drain style (`OPEN_DRAIN`=1): `rst_lvl_o` is always 0, and `rst_oe_o` is 1 exactly while in state 2.
- R8: Push-pull style (`OPEN_DRAIN`=0): `rst_oe_o` is always 1, and `rst_lvl_o` is 0 exactly while in state 2.
- R9: When a pulse ends the block enters state 3. It stays there while both buttons are low, and returns to standby on the edge after a cycle with either button high.
- R10: Both counters advance only in cycles where `tick_i` is high. Without ticks the block never leaves state 1 or state 2 on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-cycle timebase strobe |
| btn_a_n_i | input | 1 | First push button, low = pressed |
| btn_b_n_i | input | 1 | Second push button, low = pressed |
| supply_ok_i | input | 1 | Supply-good flag, high = good |
| rst_lvl_o | output | 1 | Reset pin level |
| rst_oe_o | output | 1 | Reset pin output enable |
| state_o | output | 2 | Current state (encoding in R1) |

## Verification
The assertions watch the single-step state rules on every cycle: supply-drop priority, abort on release during the hold delay, staying in standby without a valid press, holding in the wait-for-release state, freezing of the pulse when no tick arrives, and the pin encoding for the chosen output style. Exact delay and pulse lengths in ticks cannot be checked by single-step rules. The bench's cycle-accurate reference model shows these, along with the need for a full new hold delay after an abort. It also covers pulses that run through a release, back-to-back attempts without a release in between, and supply drops in each state, for both output styles.

// File: rtl/hold_reboot_pkg.sv
package hold_reboot_pkg;

    typedef enum logic [1:0] {
        HR_STANDBY = 2'd0,
        HR_DELAY   = 2'd1,
        HR_PULSE   = 2'd2,
        HR_REARM   = 2'd3
    } hr_state_e;

    typedef struct packed {
        hr_state_e st;
    } hr_fsm_s;

endpackage

// File: rtl/hr_tick_counter.sv
module hr_tick_counter #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_s;

    cnt_s cnt_d, cnt_q;
    logic at_last;

    always_comb begin
        cnt_d   = cnt_q;
        at_last = (cnt_q.cnt == LAST);
        done    = run && tick && at_last;
        if (!run) begin
            cnt_d.cnt = '0;
        end else if (tick) begin
            if (at_last) cnt_d.cnt = '0;
            else         cnt_d.cnt = cnt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/hr_out_stage.sv
module hr_out_stage #(
    parameter bit OPEN_DRAIN = 1'b1
) (
    input  logic pulse_on,
    output logic pin_lvl,
    output logic pin_oe
);
    generate
        if (OPEN_DRAIN) begin : g_od
            always_comb begin
                pin_lvl = 1'b0;
                pin_oe  = pulse_on;
            end
        end else begin : g_pp
            always_comb begin
                pin_lvl = ~pulse_on;
                pin_oe  = 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/hold_reboot_ctrl.sv
module hold_reboot_ctrl
    import hold_reboot_pkg::*;
#(
    parameter int DELAY_TICKS = 6,
    parameter int PULSE_TICKS = 4,
    parameter bit OPEN_DRAIN  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       btn_a_n_i,
    input  logic       btn_b_n_i,
    input  logic       supply_ok_i,
    output logic       rst_lvl_o,
    output logic       rst_oe_o,
    output logic [1:0] state_o
);
    hr_fsm_s fsm_d, fsm_q;

    logic both_low;
    logic dly_run, dly_done;
    logic pls_run, pls_done;
    logic pulse_on;

    always_comb begin
        both_low = ~btn_a_n_i & ~btn_b_n_i;
        dly_run  = (fsm_q.st == HR_DELAY) && supply_ok_i && both_low;
        pls_run  = (fsm_q.st == HR_PULSE) && supply_ok_i;
        pulse_on = (fsm_q.st == HR_PULSE);
    end

    hr_tick_counter #(.LIMIT(DELAY_TICKS)) u_delay_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (dly_run),
        .tick  (tick_i),
        .done  (dly_done)
    );

    hr_tick_counter #(.LIMIT(PULSE_TICKS)) u_pulse_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (pls_run),
        .tick  (tick_i),
        .done  (pls_done)
    );

    always_comb begin
        fsm_d = fsm_q;
        if (!supply_ok_i) begin
            fsm_d.st = HR_STANDBY;
        end else begin
            unique case (fsm_q.st)
                HR_STANDBY: if (both_low) fsm_d.st = HR_DELAY;
                HR_DELAY: begin
                    if (!both_low)     fsm_d.st = HR_STANDBY;
                    else if (dly_done) fsm_d.st = HR_PULSE;
                end
                HR_PULSE:   if (pls_done)  fsm_d.st = HR_REARM;
                HR_REARM:   if (!both_low) fsm_d.st = HR_STANDBY;
                default:    fsm_d.st = HR_STANDBY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q.st <= HR_STANDBY;
        else        fsm_q    <= fsm_d;
    end

    hr_out_stage #(.OPEN_DRAIN(OPEN_DRAIN)) u_out (
        .pulse_on (pulse_on),
        .pin_lvl  (rst_lvl_o),
        .pin_oe   (rst_oe_o)
    );

    assign state_o = fsm_q.st;

endmodule

// File: rtl/hold_reboot_chk.sv
module hold_reboot_chk #(
    parameter bit OPEN_DRAIN = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       btn_a_n_i,
    input logic       btn_b_n_i,
    input logic       supply_ok_i,
    input logic       rst_lvl_o,
    input logic       rst_oe_o,
    input logic [1:0] state_o
);
    // R4
    supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> (state_o == 2'd0));

    // R3
    delay_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1 && supply_ok_i && (btn_a_n_i || btn_b_n_i)) |=> (state_o == 2'd0));

    // R2
    standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && !(supply_ok_i && !btn_a_n_i && !btn_b_n_i)) |=> (state_o == 2'd0));

    // R9
    rearm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && supply_ok_i && !btn_a_n_i && !btn_b_n_i) |=> (state_o == 2'd3));

    // R10
    pulse_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 && supply_ok_i && !tick_i) |=> (state_o == 2'd2));

    // R10
    delay_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1 && supply_ok_i && !btn_a_n_i && !btn_b_n_i && !tick_i) |=> (state_o == 2'd1));

    generate
        if (OPEN_DRAIN) begin : g_od_chk
            // R7
            od_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!rst_lvl_o && (rst_oe_o == (state_o == 2'd2))));
        end else begin : g_pp_chk
            // R8
            pp_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_oe_o && (rst_lvl_o == (state_o != 2'd2))));
        end
    endgenerate

endmodule

bind hold_reboot_ctrl hold_reboot_chk #(.OPEN_DRAIN(OPEN_DRAIN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .btn_a_n_i   (btn_a_n_i),
    .btn_b_n_i   (btn_b_n_i),
    .supply_ok_i (supply_ok_i),
    .rst_lvl_o   (rst_lvl_o),
    .rst_oe_o    (rst_oe_o),
    .state_o     (state_o)
);

// File: tb/hold_reboot_ctrl_tb_top.sv
`timescale 1ns/1ps
module hold_reboot_ctrl_tb_top;
    localparam int DLY = 5;
    localparam int PLS = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic btn_a = 1'b1;
    logic btn_b = 1'b1;
    logic sup = 1'b1;
    int   tick_mode = 1;
    int   cyc = 0;

    logic       od_lvl, od_oe, pp_lvl, pp_oe;
    logic [1:0] od_st, pp_st;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int m_state = 0;
    int m_cnt   = 0;
    int m_pulses = 0;
    int od_pulses = 0;
    int pp_pulses = 0;
    logic [1:0] od_prev = 2'd0;
    logic [1:0] pp_prev = 2'd0;

    always #5 clk = ~clk;

    hold_reboot_ctrl #(.DELAY_TICKS(DLY), .PULSE_TICKS(PLS), .OPEN_DRAIN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .btn_a_n_i(btn_a), .btn_b_n_i(btn_b),
        .supply_ok_i(sup), .rst_lvl_o(od_lvl), .rst_oe_o(od_oe), .state_o(od_st));

    hold_reboot_ctrl #(.DELAY_TICKS(DLY), .PULSE_TICKS(PLS), .OPEN_DRAIN(1'b0)) dut_pp_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .btn_a_n_i(btn_a), .btn_b_n_i(btn_b),
        .supply_ok_i(sup), .rst_lvl_o(pp_lvl), .rst_oe_o(pp_oe), .state_o(pp_st));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Reference model: advances on each rising edge from the inputs held there
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0;
        end else if (!sup) begin
            m_state = 0; m_cnt = 0;
        end else begin
            case (m_state)
                0: if (!btn_a && !btn_b) begin m_state = 1; m_cnt = 0; end
                1: begin
                    if (btn_a || btn_b) begin m_state = 0; m_cnt = 0; end
                    else if (tick) begin
                        m_cnt++;
                        if (m_cnt == DLY) begin m_state = 2; m_cnt = 0; m_pulses++; end
                    end
                end
                2: if (tick) begin
                    m_cnt++;
                    if (m_cnt == PLS) begin m_state = 3; m_cnt = 0; end
                end
                default: if (btn_a || btn_b) m_state = 0;
            endcase
        end
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        string tag;
        case (m_state)
            0: tag = "R1 R2 R4";
            1: tag = "R3 R10";
            2: tag = "R5 R6";
            default: tag = "R9";
        endcase
        check(tag, od_st, m_state);
        check(tag, pp_st, m_state);
        check("R7", od_lvl, 0);
        check("R7", od_oe, (m_state == 2) ? 1 : 0);
        check("R8", pp_oe, 1);
        check("R8", pp_lvl, (m_state == 2) ? 0 : 1);
        if (od_st == 2'd2 && od_prev != 2'd2) od_pulses++;
        if (pp_st == 2'd2 && pp_prev != 2'd2) pp_pulses++;
        od_prev = od_st;
        pp_prev = pp_st;
    end

    // Tick generator
    always @(negedge clk) begin
        #1;
        case (tick_mode)
            0: tick <= 1'b0;
            1: tick <= 1'b1;
            default: tick <= ((cyc % tick_mode) == 0);
        endcase
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #2;
        end
    endtask

    task automatic drive(input logic a, input logic b, input logic s);
        @(negedge clk); #2;
        btn_a = a; btn_b = b; sup = s;
    endtask

    // Watchdog
    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); #2; rst_n = 1'b1;
        // R1: reset state
        @(negedge clk); #3;
        check("R1 reset state", od_st, 0);
        check("R1 reset pin", od_oe, 0);

        // R4: supply low blocks a valid press
        drive(0, 0, 0); idle(6);
        // R2: single button never arms
        drive(0, 1, 1); idle(6);
        drive(1, 0, 1); idle(6);
        // R3: release midway through delay
        tick_mode = 2;
        drive(0, 0, 1); idle(4);
        drive(1, 0, 1); idle(3);
        // R5, R6, R9: full hold, release during pulse
        drive(0, 0, 1); idle(2 * DLY + 2);
        drive(1, 1, 1); idle(12);
        // R9: hold through pulse, stays waiting, then release
        tick_mode = 1;
        drive(0, 0, 1); idle(DLY + PLS + 8);
        drive(0, 1, 1); idle(3);
        drive(0, 0, 1); idle(DLY + PLS + 4);
        drive(1, 1, 1); idle(3);
        // R10: no ticks freeze delay and pulse
        tick_mode = 0;
        drive(0, 0, 1); idle(10);
        tick_mode = 3;
        idle(3 * DLY + 2);
        tick_mode = 0; idle(8);
        tick_mode = 3; idle(3 * PLS + 4);
        // R4: supply drop in pulse and in waiting state
        drive(1, 1, 1); idle(2);
        tick_mode = 1;
        drive(0, 0, 1); idle(DLY + 2);
        drive(0, 0, 0); idle(3);
        drive(0, 0, 1); idle(DLY + PLS + 4);
        drive(0, 0, 0); idle(2);
        drive(0, 0, 1); idle(DLY + 3);
        drive(1, 1, 1); idle(DLY + PLS + 4);
        // R1: reset mid-pulse releases output
        drive(0, 0, 1); idle(DLY + 2);
        @(negedge clk); #2; rst_n = 1'b0;
        @(negedge clk); #3;
        check("R1 reset mid-pulse", od_st, 0);
        check("R8 reset mid-pulse pin", pp_lvl, 1);
        @(negedge clk); #2; rst_n = 1'b1; btn_a = 1'b1; btn_b = 1'b1;
        idle(4);

        check("R5 pulse count open-drain", od_pulses, m_pulses);
        check("R5 pulse count push-pull", pp_pulses, m_pulses);
        check("R6 some pulses produced", (m_pulses >= 5) ? 1 : 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule